// File: doc/BRIEF.md
# Interrupt Acknowledge Keep/Pass Controller

This block sits between three internal interrupt sources (receive, transmit, modem) and a host that acknowledges interrupts over a chain of identical devices. It drives one active-low request line per source. When the host starts an acknowledge cycle, the block compares the host's low seven address bits against a programmable level held for each source. If a requesting source's level matches, the block keeps the cycle. It then drives its vector register onto the data bus and enters that source's interrupt context. Otherwise it passes the acknowledge on to the next device in the chain.

The host programs the three level registers and the vector register through a simple write port. The entered context is reported as a valid flag and a 2-bit type code. It remains set until the host writes an end-of-interrupt strobe.

Top module: `iack_chain_ctrl`

## Requirements
- R1: Source requests are registered once; `irq_no_o[i]` equals the inverse of `src_req_i[i]` one clock after it is sampled. Bit 0 is receive, bit 1 is transmit, bit 2 is modem.
- R2: If no request is registered when `iack_ni` is low, the acknowledge is passed: `iack_no_o` follows `iack_ni` in the same cycle, and `vec_oe_o` stays low.
- R3: If requests are registered but no requesting source's level equals `addr_i`, the acknowledge is passed in the same way as in R2.
- R4: If a requesting source's level equals `addr_i`, the cycle is kept: `iack_no_o` stays high, `vec_oe_o` is high and `vec_o` carries the vector register. Whenever `vec_oe_o` is low, `vec_o` is zero.
- R5: A write with `wr_sel_i` equal to 0, 1 or 2 loads the receive, transmit or modem level from `wr_data_i[6:0]`, and `wr_data_i[7]` is discarded. `wr_sel_i` equal to 3 loads the 8-bit vector.
- R6: When several requesting sources match, receive wins over transmit and transmit wins over modem. The context type codes are 0 for receive, 1 for transmit and 2 for modem.
- R7: The keep/pass decision is taken at the first clock edge with `iack_ni` low. It is held for the rest of the cycle even if the requests change.
- R8: A kept cycle sets `ctx_valid_o` and `ctx_type_o` at that first edge. They hold until `eoi_i` is sampled high, which clears both. A kept start in the same cycle as `eoi_i` takes precedence and leaves the new context set.
- R9: When `iack_ni` returns high, `iack_no_o` goes high and `vec_oe_o` low in the same cycle.
- R10: After reset all request lines, `iack_no_o` and `ctx_valid_o` are inactive and `vec_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 3 | Source request flags (rx, tx, modem) |
| iack_ni | input | 1 | Acknowledge in, active low |
| addr_i | input | 7 | Host address bits compared with the levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0..2 level, 3 vector |
| wr_data_i | input | 8 | Write data |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_no_o | output | 3 | Request lines, active low |
| iack_no_o | output | 1 | Acknowledge out, active low |
| vec_o | output | 8 | Vector data |
| vec_oe_o | output | 1 | Vector drive enable |
| ctx_valid_o | output | 1 | Interrupt context entered |
| ctx_type_o | output | 2 | Type of the entered context |

## Verification
Two functions can fall in the same clock: accepting a new acknowledge, which sets the context, and an end-of-interrupt strobe, which clears it. The bench first leaves a context set from an earlier kept cycle. It then raises `eoi_i` in the same cycle that `iack_ni` falls onto a matching level, and expects the new type with the valid flag still set. A second case issues the strobe with no acknowledge and expects the flag cleared. The bench also sweeps every request combination against each level and one non-matching address, under three level layouts: distinct levels, all levels equal, and a partial collision.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int N_SRC = 3;
  localparam int SEL_W = $clog2(N_SRC);
  localparam int WSEL_W = $clog2(N_SRC + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_RX  = 2'd0,
    SRC_TX  = 2'd1,
    SRC_MDM = 2'd2
  } src_e;

  localparam logic [WSEL_W-1:0] WSEL_VEC = WSEL_W'(N_SRC);
endpackage

// File: rtl/iack_regs.sv
module iack_regs
  import iack_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [WSEL_W-1:0]            wr_sel_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [N_SRC-1:0][LVL_W-1:0]  lvl_o,
  output logic [VEC_W-1:0]             vec_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_o[g] <= '0;
      else if (wr_en_i && wr_sel_i == WSEL_W'(g)) lvl_o[g] <= wr_data_i[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_o <= '0;
    else if (wr_en_i && wr_sel_i == WSEL_VEC) vec_o <= wr_data_i[VEC_W-1:0];
  end
endmodule

// File: rtl/iack_match.sv
module iack_match
  import iack_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][LVL_W-1:0]  lvl_i,
  input  logic [LVL_W-1:0]             addr_i,
  output logic                         hit_o,
  output logic [SEL_W-1:0]             sel_o
);
  logic [N_SRC-1:0] cand;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign cand[g] = req_i[g] && (lvl_i[g] == addr_i);
  end

  // lowest index wins: walk downward so index 0 is assigned last
  always_comb begin
    sel_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) sel_o = SEL_W'(i);
    end
  end

  assign hit_o = |cand;
endmodule

// File: rtl/iack_cycle.sv
module iack_cycle
  import iack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iack_ni,
  input  logic             hit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             eoi_i,
  output logic             keep_now_o,
  output logic             ctx_valid_o,
  output logic [SEL_W-1:0] ctx_type_o
);
  logic active_q, keep_q, start;

  assign start = !iack_ni && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
    end else begin
      active_q <= !iack_ni;
      if (start) keep_q <= hit_i;
    end
  end

  // before the first edge of a cycle the live decision is used
  assign keep_now_o = active_q ? keep_q : hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_valid_o <= 1'b0;
      ctx_type_o  <= '0;
    end else if (start && hit_i) begin
      ctx_valid_o <= 1'b1;
      ctx_type_o  <= sel_i;
    end else if (eoi_i) begin
      ctx_valid_o <= 1'b0;
      ctx_type_o  <= '0;
    end
  end
endmodule

// File: rtl/iack_chain_ctrl.sv
module iack_chain_ctrl
  import iack_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        src_req_i,
  input  logic              iack_ni,
  input  logic [LVL_W-1:0]  addr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eoi_i,
  output logic [2:0]        irq_no_o,
  output logic              iack_no_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o,
  output logic              ctx_valid_o,
  output logic [1:0]        ctx_type_o
);
  logic [N_SRC-1:0]            req_q;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [VEC_W-1:0]            vec_q;
  logic                        hit, keep_now;
  logic [SEL_W-1:0]            sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= src_req_i;
  end

  assign irq_no_o = ~req_q;

  iack_regs #(.LVL_W(LVL_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .lvl_o     (lvl),
    .vec_o     (vec_q)
  );

  iack_match #(.LVL_W(LVL_W)) u_match (
    .req_i  (req_q),
    .lvl_i  (lvl),
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  iack_cycle u_cycle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iack_ni     (iack_ni),
    .hit_i       (hit),
    .sel_i       (sel),
    .eoi_i       (eoi_i),
    .keep_now_o  (keep_now),
    .ctx_valid_o (ctx_valid_o),
    .ctx_type_o  (ctx_type_o)
  );

  assign iack_no_o = iack_ni || keep_now;
  assign vec_oe_o  = !iack_ni && keep_now;
  assign vec_o     = vec_oe_o ? vec_q : '0;
endmodule

// File: rtl/iack_chain_ctrl_chk.sv
module iack_chain_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       src_req_i,
  input logic             iack_ni,
  input logic             eoi_i,
  input logic [2:0]       irq_no_o,
  input logic             iack_no_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_oe_o,
  input logic             ctx_valid_o
);
  a_r1_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_no_o == ~$past(src_req_i));

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_ni |-> (iack_no_o && !vec_oe_o));

  a_r4_keep_excl_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> iack_no_o);

  a_r4_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> vec_o == '0);

  a_r7_decision_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iack_ni && $past(!iack_ni) && $past(rst_ni)) |-> $stable(vec_oe_o));

  a_r8_ctx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_oe_o && !eoi_i) |=> ctx_valid_o);

  a_r8_eoi_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && iack_ni) |=> !ctx_valid_o);
endmodule

bind iack_chain_ctrl iack_chain_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_req_i   (src_req_i),
  .iack_ni     (iack_ni),
  .eoi_i       (eoi_i),
  .irq_no_o    (irq_no_o),
  .iack_no_o   (iack_no_o),
  .vec_o       (vec_o),
  .vec_oe_o    (vec_oe_o),
  .ctx_valid_o (ctx_valid_o)
);

// File: tb/tb_iack_chain_ctrl.sv
module tb_iack_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VEC = 8'hA5;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] src_req_i = '0;
  logic       iack_ni = 1'b1;
  logic [6:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       eoi_i = 1'b0;
  logic [2:0] irq_no_o;
  logic       iack_no_o;
  logic [7:0] vec_o;
  logic       vec_oe_o;
  logic       ctx_valid_o;
  logic [1:0] ctx_type_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iack_chain_ctrl dut (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic eoi_pulse();
    @(negedge clk_i); eoi_i = 1'b1;
    @(negedge clk_i); eoi_i = 1'b0;
  endtask

  logic [7:0] cfg [3][3];
  initial begin
    cfg[0][0] = 8'h85; cfg[0][1] = 8'h09; cfg[0][2] = 8'h7F; // distinct, rx bit7 dropped (R5)
    cfg[1][0] = 8'h22; cfg[1][1] = 8'h22; cfg[1][2] = 8'h22; // all equal
    cfg[2][0] = 8'h11; cfg[2][1] = 8'h11; cfg[2][2] = 8'h33; // partial collision
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R10 reset state
    chk("R10 irq", irq_no_o, 3'b111);
    chk("R10 iack_out", iack_no_o, 1);
    chk("R10 oe", vec_oe_o, 0);
    chk("R10 ctx", ctx_valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    wr(2'd3, VEC);

    for (int c = 0; c < 3; c++) begin
      for (int s = 0; s < 3; s++) wr(2'(s), cfg[c][s]);
      for (int a = 0; a < 4; a++) begin
        logic [6:0] ad;
        ad = (a < 3) ? cfg[c][a][6:0] : 7'h40;
        for (int r = 0; r < 8; r++) begin
          bit hit; int sel;
          hit = 0; sel = 0;
          for (int i = 0; i < 3; i++)
            if (!hit && r[i] && cfg[c][i][6:0] == ad) begin hit = 1; sel = i; end
          @(negedge clk_i); src_req_i = 3'(r);
          @(negedge clk_i);
          chk("R1 irq", irq_no_o, ~r & 7);
          addr_i = ad; iack_ni = 1'b0;
          #1;
          // R2/R3 pass, R4/R5/R6 keep
          chk(hit ? "R4 iack_out" : (r == 0 ? "R2 iack_out" : "R3 iack_out"), iack_no_o, hit);
          chk(hit ? "R4 oe" : "R3 oe", vec_oe_o, hit);
          chk("R4 vec", vec_o, hit ? VEC : 0);
          @(negedge clk_i);
          chk("R8 ctx_valid", ctx_valid_o, hit);
          if (hit) chk("R6 ctx_type", ctx_type_o, sel);
          src_req_i = ~3'(r);
          @(negedge clk_i);
          chk("R7 iack_out held", iack_no_o, hit);
          chk("R7 oe held", vec_oe_o, hit);
          iack_ni = 1'b1;
          #1;
          chk("R9 iack_out", iack_no_o, 1);
          chk("R9 oe", vec_oe_o, 0);
          chk("R8 ctx hold", ctx_valid_o, hit);
          eoi_pulse();
          chk("R8 eoi clear", ctx_valid_o, 0);
          src_req_i = '0;
        end
      end
    end

    // R8: start coinciding with eoi keeps the new context
    for (int s = 0; s < 3; s++) wr(2'(s), 8'(8'h10 + s));
    @(negedge clk_i); src_req_i = 3'b001;
    @(negedge clk_i); addr_i = 7'h10; iack_ni = 1'b0;
    @(negedge clk_i); iack_ni = 1'b1;
    chk("R8 first ctx", ctx_valid_o, 1);
    chk("R6 first type", ctx_type_o, 0);
    src_req_i = 3'b100;
    @(negedge clk_i); addr_i = 7'h12; iack_ni = 1'b0; eoi_i = 1'b1;
    @(negedge clk_i); eoi_i = 1'b0;
    chk("R8 start over eoi valid", ctx_valid_o, 1);
    chk("R8 start over eoi type", ctx_type_o, 2);
    iack_ni = 1'b1;
    @(negedge clk_i); eoi_i = 1'b1;
    @(negedge clk_i); eoi_i = 1'b0;
    chk("R8 eoi alone", ctx_valid_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule